// File: doc/BRIEF.md
# Differential Phase-Keyed Square-Wave Carrier Generator

This block turns a serial bit stream into a two-level differentially phase-keyed carrier in the form of a one-bit polarity signal. All of its timing comes from a single master tick enable. A bit-period counter divides the tick rate down to the symbol rate, and a second counter divides it to the carrier rate. With the default parameters there are 128 ticks per bit and 32 ticks per carrier cycle, so every bit spans exactly four whole carrier cycles.

On the first tick of each bit period the block raises a symbol strobe and takes one data bit. A 1 inverts the stored carrier phase and a 0 keeps it. The polarity output is the carrier's half-cycle indicator XORed with that phase. Phase changes only ever land on a tick where the carrier is starting a fresh cycle, so every carrier half-period keeps its full length. The output is meant to feed a separate band-limiting filter downstream.

The polarity output is registered. It takes its new value on the clock edge that consumes a tick, and it holds that value until the next tick. `TICKS_PER_BIT` must be a whole multiple of `TICKS_PER_CYCLE`, and `TICKS_PER_CYCLE` must be even.

Top module: `dpsk_sqw_mod`

## Requirements
- R1: While `rst` is high at a clock edge, and right after it, `carrier_out` is 0, `phase_q` is 0, and both counters are at tick index 0.
- R2: `sym_strobe` is high exactly in those clock cycles where `tick_en` is high and the tick index within the bit period is 0. It therefore pulses once per `TICKS_PER_BIT` ticks.
- R3: `data_in` is ignored on every tick other than the strobe tick and in every cycle without a tick. `phase_q` and `carrier_out` do not depend on it there.
- R4: On a strobe tick, a `data_in` of 1 inverts `phase_q` and a 0 leaves it unchanged. The new phase is visible after that clock edge.
- R5: After the edge that consumes tick index k of a bit, `carrier_out` equals ((k mod `TICKS_PER_CYCLE`) >= `TICKS_PER_CYCLE`/2) XOR the phase of that bit. On tick 0 of a bit the carrier half indicator is therefore 0.
- R6: In a cycle with `tick_en` low, `carrier_out`, `phase_q` and the tick position all hold their values.
- R7: The first bit after reset is referenced to phase 0, so the phase after the first strobe equals that first data bit.
- R8: A reset in the middle of a bit period wins over a simultaneous tick. The next tick after reset is a strobe tick at index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Master tick enable, one tick per high cycle |
| data_in | input | 1 | Serial data bit, sampled on the strobe tick |
| carrier_out | output | 1 | Keyed square-wave carrier polarity (registered) |
| sym_strobe | output | 1 | High during the tick that starts a bit period |
| phase_q | output | 1 | Carrier phase state of the current bit |

## Verification
The bench drives the complement of the real bit on every non-strobe tick. A design that sampled data on the wrong tick, or on every tick, would therefore show a phase flip in the middle of a bit. Outputs are compared on every tick around the half-cycle turnovers and on the bit boundary. A design that applied the new phase one tick late would emit a one-tick glitch at the start of the bit, and a carrier counter out of step with the bit counter would put the flip inside a half-period. Directed cases cover a reset in the middle of a bit while a tick is present, which must restart the strobe cadence at the next tick, and long gaps with no tick, in which a design that kept counting would drift.

// File: rtl/dpskm_pkg.sv
package dpskm_pkg;

  // Next value of a wrapping tick counter with period 'period'.
  function automatic int unsigned wrap_next(input int unsigned cnt, input int unsigned period);
    return (cnt >= period - 1) ? 0 : cnt + 1;
  endfunction

  // True when 'cnt' is in the second half of a cycle of length 'period'.
  function automatic logic upper_half(input int unsigned cnt, input int unsigned period);
    return (cnt % period) >= (period / 2);
  endfunction

  // Phase after a boundary: a 1 inverts, a 0 keeps.
  function automatic logic keyed_phase(input logic phase, input logic take, input logic bit_in);
    return phase ^ (take & bit_in);
  endfunction

endpackage

// File: rtl/dpskm_bit_timer.sv
module dpskm_bit_timer #(
  parameter int unsigned TICKS_PER_BIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic bit_start
);
  import dpskm_pkg::*;

  localparam int unsigned CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (tick_en)
      cnt_q <= CW'(wrap_next(int'(cnt_q), TICKS_PER_BIT));
  end

  assign bit_start = (cnt_q == '0);

endmodule

// File: rtl/dpskm_carrier_ctr.sv
module dpskm_carrier_ctr #(
  parameter int unsigned TICKS_PER_CYCLE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic upper
);
  import dpskm_pkg::*;

  localparam int unsigned CW = (TICKS_PER_CYCLE > 1) ? $clog2(TICKS_PER_CYCLE) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (tick_en)
      cnt_q <= CW'(wrap_next(int'(cnt_q), TICKS_PER_CYCLE));
  end

  assign upper = upper_half(int'(cnt_q), TICKS_PER_CYCLE);

endmodule

// File: rtl/dpskm_phase_reg.sv
module dpskm_phase_reg (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic bit_in,
  output logic phase_now,
  output logic phase_next
);
  import dpskm_pkg::*;

  logic phase_q;

  assign phase_next = keyed_phase(phase_q, take, bit_in);

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= 1'b0;
    else
      phase_q <= phase_next;
  end

  assign phase_now = phase_q;

endmodule

// File: rtl/dpsk_sqw_mod.sv
module dpsk_sqw_mod #(
  parameter int unsigned TICKS_PER_BIT   = 128,
  parameter int unsigned TICKS_PER_CYCLE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic data_in,
  output logic carrier_out,
  output logic sym_strobe,
  output logic phase_q
);

  logic bit_start;
  logic carrier_half;
  logic strobe;
  logic phase_now;
  logic phase_next;
  logic out_q;

  dpskm_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bit (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bit_start (bit_start)
  );

  dpskm_carrier_ctr #(.TICKS_PER_CYCLE(TICKS_PER_CYCLE)) u_car (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .upper   (carrier_half)
  );

  assign strobe = tick_en & bit_start;

  dpskm_phase_reg u_ph (
    .clk        (clk),
    .rst        (rst),
    .take       (strobe),
    .bit_in     (data_in),
    .phase_now  (phase_now),
    .phase_next (phase_next)
  );

  // Output carries the polarity of the tick just consumed, new phase included.
  always_ff @(posedge clk) begin
    if (rst)
      out_q <= 1'b0;
    else if (tick_en)
      out_q <= carrier_half ^ phase_next;
  end

  assign carrier_out = out_q;
  assign sym_strobe  = strobe;
  assign phase_q     = phase_now;

endmodule

// File: rtl/dpskm_checker.sv
module dpskm_checker #(
  parameter int unsigned TICKS_PER_BIT   = 128,
  parameter int unsigned TICKS_PER_CYCLE = 32
) (
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic data_in,
  input logic carrier_out,
  input logic sym_strobe,
  input logic phase_q,
  input logic carrier_half
);

  localparam int unsigned CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [CW-1:0] chk_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      chk_cnt <= '0;
    else if (tick_en)
      chk_cnt <= (chk_cnt == CW'(TICKS_PER_BIT - 1)) ? '0 : chk_cnt + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!carrier_out && !phase_q));

  p_strobe_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    sym_strobe |-> tick_en);

  p_strobe_cadence_r2: assert property (@(posedge clk) disable iff (rst)
    tick_en |-> (sym_strobe == (chk_cnt == '0)));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sym_strobe |=> $stable(phase_q));

  p_phase_key_r4: assert property (@(posedge clk) disable iff (rst)
    sym_strobe |=> (phase_q == ($past(phase_q) ^ $past(data_in))));

  p_boundary_clean_r5: assert property (@(posedge clk) disable iff (rst)
    sym_strobe |-> !carrier_half);

  p_boundary_out_r5: assert property (@(posedge clk) disable iff (rst)
    sym_strobe |=> (carrier_out == phase_q));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(carrier_out));

endmodule

bind dpsk_sqw_mod dpskm_checker #(
  .TICKS_PER_BIT   (TICKS_PER_BIT),
  .TICKS_PER_CYCLE (TICKS_PER_CYCLE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_en      (tick_en),
  .data_in      (data_in),
  .carrier_out  (carrier_out),
  .sym_strobe   (sym_strobe),
  .phase_q      (phase_q),
  .carrier_half (carrier_half)
);

// File: tb/sim_dpsk_sqw_mod.sv
module sim_dpsk_sqw_mod;

  localparam int TPB = 128;
  localparam int TPC = 32;

  // Each entry: {data bit on the strobe tick, expected phase for that bit}
  localparam logic [1:0] VEC [8] = '{2'b11, 2'b01, 2'b10, 2'b11,
                                     2'b01, 2'b01, 2'b10, 2'b00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic data_in = 1'b0;
  logic carrier_out, sym_strobe, phase_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpsk_sqw_mod #(.TICKS_PER_BIT(TPB), .TICKS_PER_CYCLE(TPC)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .data_in(data_in),
    .carrier_out(carrier_out), .sym_strobe(sym_strobe), .phase_q(phase_q)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic model_out(input int k, input logic ph);
    return logic'((k % TPC) >= (TPC / 2)) ^ ph;
  endfunction

  // One tick: strobe is checked before the edge, outputs after it.
  task automatic do_tick(input logic d, input logic exp_stb, input logic exp_out,
                         input logic exp_ph, input string tag);
    @(negedge clk);
    tick_en = 1'b1;
    data_in = d;
    #1;
    check(sym_strobe, exp_stb, "R2", "sym_strobe");
    @(negedge clk);
    tick_en = 1'b0;
    data_in = ~d;
    check(carrier_out, exp_out, "R5", "carrier_out");
    check(phase_q, exp_ph, tag, "phase_q");
  endtask

  task automatic idle_check(input logic exp_out, input logic exp_ph);
    @(negedge clk);
    check(sym_strobe, 1'b0, "R6", "sym_strobe idle");
    check(carrier_out, exp_out, "R6", "carrier_out idle");
    check(phase_q, exp_ph, "R6", "phase_q idle");
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(carrier_out, 1'b0, "R1", "carrier_out in reset");
    check(phase_q, 1'b0, "R1", "phase_q in reset");
    rst = 1'b0;
    #1;
    check(sym_strobe, 1'b0, "R1", "no strobe without tick");

    // Table walk: eight bits, junk data on every non-strobe tick (R3, R4, R5)
    for (int b = 0; b < 8; b++) begin
      for (int t = 0; t < TPB; t++) begin
        logic d;
        logic ph;
        d  = (t == 0) ? VEC[b][1] : ~VEC[b][1];
        ph = VEC[b][0];
        do_tick(d, (t == 0), model_out(t, ph), ph, (t == 0) ? ((b == 0) ? "R7" : "R4") : "R3");
        if (t % 8 == 0) idle_check(model_out(t, ph), ph);
      end
    end

    // R6: long gap with no tick, data toggling
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      data_in = i[0];
    end
    #1;
    check(sym_strobe, 1'b0, "R6", "sym_strobe after gap");
    check(phase_q, 1'b0, "R6", "phase_q after gap");
    check(carrier_out, model_out(TPB - 1, 1'b0), "R6", "carrier_out after gap");
    // next tick must still be a strobe tick (position held through the gap)
    do_tick(1'b1, 1'b1, 1'b1, 1'b1, "R6");

    // R8: reset mid-bit, with a tick present on the reset cycle
    for (int t = 1; t < 50; t++) do_tick(1'b0, 1'b0, model_out(t, 1'b1), 1'b1, "R3");
    @(negedge clk);
    rst = 1'b1;
    tick_en = 1'b1;
    data_in = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    tick_en = 1'b0;
    check(phase_q, 1'b0, "R8", "phase_q after mid-bit reset");
    check(carrier_out, 1'b0, "R8", "carrier_out after mid-bit reset");
    do_tick(1'b0, 1'b1, 1'b0, 1'b0, "R8");
    for (int t = 1; t < TPB; t++) do_tick(1'b1, 1'b0, model_out(t, 1'b0), 1'b0, "R3");
    do_tick(1'b1, 1'b1, 1'b1, 1'b1, "R4");
    do_tick(1'b0, 1'b0, 1'b1, 1'b1, "R5");

    finish_run();
  end

endmodule